// File: doc/BRIEF.md
# Vertical Line-Buffered Video Scaler

This block produces the vertical half of a video resize. It receives a stream of pixel lines that are already at the output width. For every input frame it emits a frame with a programmed number of output lines. Each output line is blended from two neighbouring source lines. A fractional line position selects the pair: a 12.12 fixed-point accumulator that advances by the vertical pitch (source lines divided by output lines, times 4096) after every output line. The top four fraction bits of that position pick one of sixteen weight pairs from a writable coefficient table.

Only two source lines are held, in two linestores whose depth is a synthesis parameter. The block therefore never buffers a whole frame. It alternates between two activities. It loads source lines until the two lines that the next output line needs are present. It then issues that output line while the input is held off. Both sides use a valid/ready handshake. The output carries regenerated frame-start and line-start flags.

Top module: `vscale_core`

## Requirements
- R1: During and right after reset, `m_valid` is low and `s_ready` is high, and the block waits for a frame start.
- R2: Input pixels accepted before a pixel with `s_vsync` high are dropped and have no effect on the next output frame. The pixel carrying `s_vsync` is source line 0, column 0.
- R3: Each input frame yields exactly `cfg_dst_lines` × `cfg_line_px` output pixels, with no extra pixels afterwards.
- R4: Output line j is built from source position P = j × `cfg_pitch_y` in 12.12 format. The upper tap is source line k = P >> 12, the lower tap is line k+1, and the phase is bits [11:8] of P.
- R5: Each 8-bit channel (bits [23:16], [15:8], [7:0]) becomes (upper × wt + lower × wb + 64) >> 7, saturated at 255, where wt and wb are the table's weights for the phase.
- R6: k is clamped to `cfg_src_lines` − 1. When k+1 would pass the last source line, the lower tap repeats line k.
- R7: `m_vsync` is high only on the first pixel of an output frame. `m_hsync` is high only on the first pixel of each output line.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` stay unchanged.
- R9: After reset, phase p holds wt = 128 − 8p and wb = 8p. A cycle with `coef_we` high replaces the pair of phase `coef_phase` with `coef_top`/`coef_bot` for all later lines.
- R10: While an output line is still being issued (before its last pixel leaves the blend stage), `s_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pitch_y | input | 24 | Vertical pitch, 12.12 unsigned |
| cfg_src_lines | input | 16 | Source lines per frame (at least 1) |
| cfg_line_px | input | 16 | Pixels per line, in and out (at most linestore depth) |
| cfg_dst_lines | input | 16 | Output lines per frame (at least 1) |
| coef_we | input | 1 | Coefficient write strobe |
| coef_phase | input | 4 | Phase written |
| coef_top | input | 8 | Upper-tap weight |
| coef_bot | input | 8 | Lower-tap weight |
| s_data | input | 24 | Input pixel |
| s_vsync | input | 1 | Input frame start |
| s_hsync | input | 1 | Input line start, forces column 0 |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted |
| m_data | output | 24 | Output pixel |
| m_vsync | output | 1 | Output frame start |
| m_hsync | output | 1 | Output line start |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Output pixel taken |

## Verification
The frames used cover several cases that the line selection must tell apart:
- A unit pitch, where each line must pass through unchanged and a wrong phase shows at once.
- Upscaling pitches with non-zero fractions, which exercise the blend and the bottom-line repeat.
- Downscaling by two and by four, where k skips lines and the unused tail of the frame must still be absorbed.
- A pitch that overshoots the frame, which exercises the clamp.
- A one-pixel-wide frame.

Further frames are preceded by stray pixels without a frame start, or run with reprogrammed weights, including weights whose sum saturates. Both handshakes are throttled by pseudo-random patterns, so output stalls land in the middle of lines.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  localparam int CH_W    = 8;
  localparam int NCH     = 3;
  localparam int PIX_W   = CH_W * NCH;
  localparam int PH_BITS = 4;
  localparam int NPH     = 1 << PH_BITS;
  localparam int CW      = 8;
  localparam int CSHIFT  = 7;
  localparam int SUM_W   = CH_W + CW + 1;
  localparam int LN_W    = 16;
  localparam int PITCH_W = 24;
  localparam int FRAC_W  = 12;
  localparam int ACC_W   = 32;
  localparam int INT_W   = ACC_W - FRAC_W;

  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [CW-1:0]    coef_t;
  typedef logic [LN_W-1:0]  line_t;
  typedef struct packed { coef_t top; coef_t bot; } tap_pair_t;
  typedef enum logic [1:0] {ST_SYNC, ST_LOAD, ST_EMIT, ST_DRAIN} vst_t;

  // Straight-line weights: lower tap grows by 8 per phase.
  function automatic tap_pair_t bilinear_taps(input logic [PH_BITS-1:0] ph);
    tap_pair_t t;
    t.bot = coef_t'({ph, {(CSHIFT-PH_BITS){1'b0}}});
    t.top = coef_t'(1 << CSHIFT) - t.bot;
    return t;
  endfunction

  function automatic logic [CH_W-1:0] mix_chan(input logic [CH_W-1:0] a,
                                               input logic [CH_W-1:0] b,
                                               input coef_t wa, input coef_t wb);
    logic [SUM_W-1:0] s;
    s = SUM_W'(a) * SUM_W'(wa) + SUM_W'(b) * SUM_W'(wb) + (SUM_W'(1) << (CSHIFT-1));
    s = s >> CSHIFT;
    if (s > SUM_W'({CH_W{1'b1}})) return {CH_W{1'b1}};
    return s[CH_W-1:0];
  endfunction

  // Upper-tap source line, held inside the frame.
  function automatic line_t clamp_line(input logic [INT_W-1:0] ai, input line_t n);
    if (ai >= INT_W'(n)) return n - line_t'(1);
    return line_t'(ai);
  endfunction

  function automatic logic is_last_line(input line_t k, input line_t n);
    return (LN_W+1)'(k) + (LN_W+1)'(1) >= (LN_W+1)'(n);
  endfunction

  // Source lines that must have arrived before line k can be blended.
  function automatic logic [LN_W:0] lines_needed(input line_t k, input line_t n);
    if (is_last_line(k, n)) return (LN_W+1)'(n);
    return (LN_W+1)'(k) + (LN_W+1)'(2);
  endfunction
endpackage

// File: rtl/vsc_linestore.sv
module vsc_linestore #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int DW    = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vsc_coef_bank.sv
module vsc_coef_bank
  import vsc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [PH_BITS-1:0] wphase,
  input  coef_t              wtop,
  input  coef_t              wbot,
  input  logic [PH_BITS-1:0] rphase,
  output tap_pair_t          taps
);
  tap_pair_t tab [NPH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPH; p++) tab[p] <= bilinear_taps(PH_BITS'(p));
    end else if (we) begin
      tab[wphase] <= '{top: wtop, bot: wbot};
    end
  end

  assign taps = tab[rphase];
endmodule

// File: rtl/vsc_blend.sv
module vsc_blend
  import vsc_pkg::*;
(
  input  pix_t      upper,
  input  pix_t      lower,
  input  tap_pair_t taps,
  output pix_t      mixed
);
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign mixed[c*CH_W +: CH_W] = mix_chan(upper[c*CH_W +: CH_W],
                                            lower[c*CH_W +: CH_W],
                                            taps.top, taps.bot);
  end
endmodule

// File: rtl/vscale_core.sv
module vscale_core
  import vsc_pkg::*;
#(
  parameter int LINE_W  = 64,
  parameter int LINE_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PITCH_W-1:0] cfg_pitch_y,
  input  logic [LN_W-1:0]    cfg_src_lines,
  input  logic [LN_W-1:0]    cfg_line_px,
  input  logic [LN_W-1:0]    cfg_dst_lines,
  input  logic               coef_we,
  input  logic [PH_BITS-1:0] coef_phase,
  input  logic [CW-1:0]      coef_top,
  input  logic [CW-1:0]      coef_bot,
  input  logic [PIX_W-1:0]   s_data,
  input  logic               s_vsync,
  input  logic               s_hsync,
  input  logic               s_valid,
  output logic               s_ready,
  output logic [PIX_W-1:0]   m_data,
  output logic               m_vsync,
  output logic               m_hsync,
  output logic               m_valid,
  input  logic               m_ready
);
  localparam int NBANK = 2;

  vst_t              state;
  line_t             col, have, rd_col, oline;
  logic [ACC_W-1:0]  acc;

  // Named events, shared with the checker.
  logic              take, line_end, evt_issue, evt_oline_done, evt_frame_done;
  logic              loaded_enough, out_free;
  line_t             k_sel, wr_col, wr_line;
  logic [LN_W:0]     need;
  logic [PH_BITS-1:0] phase;
  logic              top_bank, bot_bank;
  pix_t              bank_rd [NBANK];
  pix_t              mixed;
  tap_pair_t         taps;

  assign k_sel         = clamp_line(acc[ACC_W-1:FRAC_W], cfg_src_lines);
  assign need          = lines_needed(k_sel, cfg_src_lines);
  assign phase         = acc[FRAC_W-1 -: PH_BITS];
  assign loaded_enough = {1'b0, have} >= need;

  always_comb begin
    unique case (state)
      ST_SYNC:  s_ready = 1'b1;
      ST_LOAD:  s_ready = !loaded_enough;
      ST_DRAIN: s_ready = have < cfg_src_lines;
      default:  s_ready = 1'b0;
    endcase
  end

  assign take     = s_valid && s_ready && (state != ST_SYNC || s_vsync);
  assign wr_col   = (state == ST_SYNC || s_hsync) ? '0 : col;
  assign wr_line  = (state == ST_SYNC) ? '0 : have;
  assign line_end = take && (wr_col == cfg_line_px - line_t'(1));

  assign out_free       = !m_valid || m_ready;
  assign evt_issue      = (state == ST_EMIT) && out_free;
  assign evt_oline_done = evt_issue && (rd_col == cfg_line_px - line_t'(1));
  assign evt_frame_done = evt_oline_done && (oline == cfg_dst_lines - line_t'(1));

  // Source line n lives in bank n[0]; at the bottom both taps share a bank.
  assign top_bank = k_sel[0];
  assign bot_bank = is_last_line(k_sel, cfg_src_lines) ? k_sel[0] : ~k_sel[0];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    vsc_linestore #(.DEPTH(LINE_W), .AW(LINE_AW), .DW(PIX_W)) u_store (
      .clk   (clk),
      .we    (take && (wr_line[0] == 1'(b))),
      .waddr (wr_col[LINE_AW-1:0]),
      .wdata (s_data),
      .raddr (rd_col[LINE_AW-1:0]),
      .rdata (bank_rd[b])
    );
  end

  vsc_coef_bank u_coef (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (coef_we),
    .wphase (coef_phase),
    .wtop   (coef_top),
    .wbot   (coef_bot),
    .rphase (phase),
    .taps   (taps)
  );

  vsc_blend u_blend (
    .upper (bank_rd[top_bank]),
    .lower (bank_rd[bot_bank]),
    .taps  (taps),
    .mixed (mixed)
  );

  // Input side: column and line counters.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col  <= '0;
      have <= '0;
    end else if (take) begin
      col  <= line_end ? '0 : wr_col + line_t'(1);
      have <= line_end ? wr_line + line_t'(1) : wr_line;
    end
  end

  // Sequencing and output position.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_SYNC;
      acc    <= '0;
      rd_col <= '0;
      oline  <= '0;
    end else begin
      unique case (state)
        ST_SYNC: if (take) begin
          acc    <= '0;
          rd_col <= '0;
          oline  <= '0;
          state  <= ST_LOAD;
        end
        ST_LOAD: if (loaded_enough) state <= ST_EMIT;
        ST_EMIT: begin
          if (evt_oline_done) begin
            acc    <= acc + ACC_W'(cfg_pitch_y);
            rd_col <= '0;
            oline  <= oline + line_t'(1);
            state  <= evt_frame_done ? ST_DRAIN : ST_LOAD;
          end else if (evt_issue) begin
            rd_col <= rd_col + line_t'(1);
          end
        end
        default: if (have >= cfg_src_lines) state <= ST_SYNC;
      endcase
    end
  end

  // Output register: holds while the sink stalls.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_hsync <= 1'b0;
      m_vsync <= 1'b0;
    end else if (evt_issue) begin
      m_valid <= 1'b1;
      m_data  <= mixed;
      m_hsync <= (rd_col == '0);
      m_vsync <= (rd_col == '0) && (oline == '0);
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vsc_props.sv
module vsc_props
  import vsc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             m_valid,
  input logic             m_ready,
  input logic [PIX_W-1:0] m_data,
  input logic             m_vsync,
  input logic             m_hsync,
  input logic             s_ready,
  input logic             evt_issue,
  input logic             evt_frame_done,
  input logic [LN_W-1:0]  k_sel,
  input logic [LN_W-1:0]  cfg_src_lines,
  input logic [LN_W-1:0]  cfg_line_px,
  input logic [LN_W-1:0]  cfg_dst_lines
);
  logic [31:0] issued;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) issued <= '0;
    else if (evt_frame_done) issued <= '0;
    else if (evt_issue) issued <= issued + 32'd1;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_hsync)); // R8

  AST_VSYNC_ON_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_vsync |-> m_hsync); // R7

  AST_FRAME_PIXELS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame_done |-> (issued + 32'd1 == 32'(cfg_line_px) * 32'(cfg_dst_lines))); // R3

  AST_TAP_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    evt_issue |-> k_sel < cfg_src_lines); // R6

  AST_INPUT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    evt_issue |-> !s_ready); // R10
endmodule

bind vscale_core vsc_props u_props (
  .clk            (clk),
  .rst_n          (rst_n),
  .m_valid        (m_valid),
  .m_ready        (m_ready),
  .m_data         (m_data),
  .m_vsync        (m_vsync),
  .m_hsync        (m_hsync),
  .s_ready        (s_ready),
  .evt_issue      (evt_issue),
  .evt_frame_done (evt_frame_done),
  .k_sel          (k_sel),
  .cfg_src_lines  (cfg_src_lines),
  .cfg_line_px    (cfg_line_px),
  .cfg_dst_lines  (cfg_dst_lines)
);

// File: tb/sim_vscale_core.sv
module sim_vscale_core;
  import vsc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  localparam int WATCHDOG = 150000;
  // {source lines, output lines, pixels per line, pitch}
  localparam int VEC [NVEC][4] = '{
    '{4, 4, 5, 4096},
    '{4, 6, 4, 2730},
    '{6, 3, 3, 8192},
    '{5, 8, 2, 2560},
    '{3, 4, 2, 5000},
    '{8, 2, 4, 16384},
    '{2, 5, 1, 1638}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:0] cfg_pitch_y = '0;
  logic [15:0] cfg_src_lines = 16'd1, cfg_line_px = 16'd1, cfg_dst_lines = 16'd1;
  logic coef_we = 1'b0;
  logic [3:0] coef_phase = '0;
  logic [7:0] coef_top = '0, coef_bot = '0;
  logic [23:0] s_data = '0;
  logic s_vsync = 1'b0, s_hsync = 1'b0, s_valid = 1'b0;
  logic s_ready;
  logic [23:0] m_data;
  logic m_vsync, m_hsync, m_valid;
  logic m_ready = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int cw_top [16];
  int cw_bot [16];
  logic [15:0] rng_in = 16'hACE1;
  logic [15:0] rng_out = 16'h1D2F;

  always #(CLK_PERIOD/2) clk = ~clk;

  vscale_core u0 (
    .clk(clk), .rst_n(rst_n), .cfg_pitch_y(cfg_pitch_y), .cfg_src_lines(cfg_src_lines),
    .cfg_line_px(cfg_line_px), .cfg_dst_lines(cfg_dst_lines), .coef_we(coef_we),
    .coef_phase(coef_phase), .coef_top(coef_top), .coef_bot(coef_bot), .s_data(s_data),
    .s_vsync(s_vsync), .s_hsync(s_hsync), .s_valid(s_valid), .s_ready(s_ready),
    .m_data(m_data), .m_vsync(m_vsync), .m_hsync(m_hsync), .m_valid(m_valid),
    .m_ready(m_ready)
  );

  function automatic logic [15:0] lfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [23:0] gen(input int tag, input int l, input int c);
    logic [7:0] r, g, b;
    r = 8'(tag * 13 + l * 37 + c * 5);
    g = 8'(l * 71 + c * 29 + tag);
    b = 8'(250 - l * 19 - c * 3 + tag);
    return {r, g, b};
  endfunction

  // Restated model: position j*pitch, clamp, repeat at bottom, rounded weights.
  function automatic logic [23:0] expect_pix(input int tag, input int j, input int c,
                                             input int src, input int pitch);
    longint pos;
    int k, kb, ph, v;
    logic [23:0] a, b, res;
    pos = longint'(j) * longint'(pitch);
    k = int'(pos / 4096);
    ph = int'((pos / 256) % 16);
    if (k > src - 1) k = src - 1;
    kb = (k + 1 > src - 1) ? k : k + 1;
    a = gen(tag, k, c);
    b = gen(tag, kb, c);
    for (int ch = 0; ch < 3; ch++) begin
      v = (int'(a[ch*8 +: 8]) * cw_top[ph] + int'(b[ch*8 +: 8]) * cw_bot[ph] + 64) / 128;
      if (v > 255) v = 255;
      res[ch*8 +: 8] = 8'(v);
    end
    return res;
  endfunction

  function automatic bit at_bottom(input int j, input int src, input int pitch);
    longint pos;
    pos = longint'(j) * longint'(pitch);
    return (pos / 4096) + 1 > longint'(src - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive_frame(input int tag, input int src, input int ppl, input int junk);
    int n, idx, all;
    n = 0;
    all = junk + src * ppl;
    while (n < all) begin
      @(negedge clk);
      rng_in = lfsr(rng_in);
      if (rng_in[0] && rng_in[3]) begin
        s_valid = 1'b0;
        s_data = {rng_in, rng_in[7:0]};
        s_vsync = rng_in[5];
        s_hsync = rng_in[6];
      end else begin
        s_valid = 1'b1;
        if (n < junk) begin
          s_data = {rng_in[7:0], rng_in};
          s_vsync = 1'b0;
          s_hsync = rng_in[2];
        end else begin
          idx = n - junk;
          s_data = gen(tag, idx / ppl, idx % ppl);
          s_vsync = (idx == 0);
          s_hsync = (idx % ppl == 0);
        end
        if (s_ready) n++;
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_vsync = 1'b0;
    s_hsync = 1'b0;
  endtask

  task automatic collect(input int tag, input int src, input int dst, input int ppl,
                         input int pitch, input string dreq);
    int idx, j, c;
    bit stall_prev;
    logic [23:0] held, e;
    string rq;
    idx = 0;
    stall_prev = 0;
    held = '0;
    while (idx < dst * ppl) begin
      @(negedge clk);
      if (stall_prev)
        chk(m_valid && m_data == held, "R8", "held pixel", longint'({m_valid, m_data}),
            longint'({1'b1, held}));
      rng_out = lfsr(rng_out);
      m_ready = rng_out[1] | rng_out[4];
      if (m_valid) begin
        j = idx / ppl;
        c = idx % ppl;
        if (m_ready) begin
          e = expect_pix(tag, j, c, src, pitch);
          if (dreq != "") rq = dreq;
          else rq = at_bottom(j, src, pitch) ? "R6" : "R4";
          chk(m_data == e, rq, $sformatf("line %0d col %0d", j, c), longint'(m_data),
              longint'(e));
          chk(m_vsync == (idx == 0) && m_hsync == (c == 0), "R7", "sync flags",
              longint'({m_vsync, m_hsync}), longint'({idx == 0, c == 0}));
          if (c < ppl - 1)
            chk(!s_ready, "R10", "input held off mid-line", longint'(s_ready), 0);
          idx++;
        end
      end
      stall_prev = m_valid && !m_ready;
      held = m_data;
    end
    @(negedge clk);
    m_ready = 1'b1;
  endtask

  task automatic run_frame(input int tag, input int src, input int dst, input int ppl,
                           input int pitch, input int junk, input string dreq);
    bit extra;
    cfg_src_lines = 16'(src);
    cfg_dst_lines = 16'(dst);
    cfg_line_px = 16'(ppl);
    cfg_pitch_y = 24'(pitch);
    fork
      drive_frame(tag, src, ppl, junk);
      collect(tag, src, dst, ppl, pitch, dreq);
    join
    extra = 0;
    repeat (20) begin
      @(negedge clk);
      if (m_valid) extra = 1;
    end
    chk(!extra, "R3", "no pixels beyond frame", longint'(extra), 0);
    m_ready = 1'b0;
  endtask

  task automatic write_coef(input int ph, input int top, input int bot);
    @(negedge clk);
    coef_we = 1'b1;
    coef_phase = 4'(ph);
    coef_top = 8'(top);
    coef_bot = 8'(bot);
    @(negedge clk);
    coef_we = 1'b0;
    cw_top[ph] = top;
    cw_bot[ph] = bot;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    for (int p = 0; p < 16; p++) begin
      cw_top[p] = 128 - 8 * p;
      cw_bot[p] = 8 * p;
    end
    repeat (3) @(negedge clk);
    chk(!m_valid && s_ready, "R1", "in reset", longint'({m_valid, s_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!m_valid && s_ready, "R1", "after reset", longint'({m_valid, s_ready}), 1);

    // Default bilinear table exercised by the vector walk (R9 defaults).
    for (int v = 0; v < NVEC; v++)
      run_frame(v + 1, VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 0, "");

    // R2: stray pixels before the frame start must be dropped.
    run_frame(21, 4, 6, 4, 2730, 7, "R2");

    // R9: rewritten phase 0 selects the lower line at unit pitch.
    write_coef(0, 0, 128);
    run_frame(31, 4, 4, 3, 4096, 0, "R9");

    // R5: weights summing past unity saturate each channel.
    write_coef(0, 200, 200);
    run_frame(41, 3, 3, 4, 4096, 0, "R5");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule